// File: doc/BRIEF.md
# Debug command port sequencer

This block is the host-side engine for the bit-serial debug command port of a 6502 bus monitor. A client hands it one high-level request at a time: read a memory byte, write a memory byte, load a breakpoint slot, take a single step, or clear the trace FIFO. The block expands each request into an exact burst of 4-bit command codes. Each code is qualified by a strobe line, and the target acts on that strobe only at a low-to-high transition, which it first passes through a two-stage synchronizer.

Addresses, data and breakpoint words cross the port one bit per strobed command, least significant bit first, into shift registers on the target. Memory transfers end with a dedicated execute code. After a read, the block waits a fixed time derived from the clock frequency. It then drives readback select 7 and captures the returned byte from the 8-bit readback bus. Every strobe pulse has a programmable low time and a programmable high time, so that a target on a slower clock sees every edge.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_strobe is 0, cmd_code is 0, rd_valid is 0 and rb_sel is 0.
- R2: Each command occupies one slot. In that slot cmd_code is steady, and cmd_strobe is low for LO_CYC clocks and then high for HI_CYC clocks. Outside a burst, cmd_code is 0 and cmd_strobe is 0.
- R3: A read (req_op 0) sends 16 commands with code {3'b110, b}, where b runs over req_addr bit 0 to bit 15, followed by code 4'b1110.
- R4: A write (req_op 1) sends the 8 req_data bits and then the 16 req_addr bits, LSB first, each as {3'b110, b}, followed by code 4'b1111.
- R5: A breakpoint load (req_op 2) sends a 26-bit word LSB first as {3'b010, b}, with no execute code. Bits 15:0 of the word are req_addr. Bits 21:16 are req_mode, holding in ascending order break-on-instruction, break-on-read, break-on-write, watch-on-instruction, watch-on-read and watch-on-write. Bits 25:22 are req_trig, the enable for each external trigger state.
- R6: A single step (req_op 3) sends the one code 4'b1000, and a trace FIFO clear (req_op 4) sends the one code 4'b1010.
- R7: After the execute slot of a read, rb_sel is 7 and cmd_strobe is 0 for WAIT_CYC clocks, where WAIT_CYC = (CLK_HZ/10^6)*WAIT_NS/1000 with a minimum of 1. The next cycle pulses rd_valid for exactly one clock, and rd_data carries the rb_data value sampled at the end of the wait.
- R8: req_ready falls the cycle after a request is accepted and stays low until the burst ends. A req_valid seen while req_ready is low is ignored.
- R9: req_ready returns the cycle after the last slot of a write, breakpoint, step or clear, and in the rd_valid cycle of a read. A request held valid there is accepted back to back.
- R10: req_op values 5, 6 and 7 are ignored: req_ready stays 1 and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request kind (0 read, 1 write, 2 breakpoint, 3 step, 4 trace clear) |
| req_addr | input | ADDR_W | Memory or breakpoint address |
| req_data | input | DATA_W | Write data |
| req_mode | input | MODE_W | Breakpoint and watch mode flags |
| req_trig | input | TRIG_W | Trigger-state enables for a breakpoint |
| req_ready | output | 1 | Idle and able to accept |
| rd_valid | output | 1 | One-cycle pulse carrying a read result |
| rd_data | output | DATA_W | Byte returned by a read |
| cmd_code | output | 4 | Command code to the target |
| cmd_strobe | output | 1 | Command strobe, acted on at its rising edge |
| rb_sel | output | 4 | Readback select |
| rb_data | input | DATA_W | Readback bus from the target |

## Verification
The reference model expands each accepted request into per-cycle expectations for code, strobe, ready, select and read result, and compares them on every clock. Reads go to addresses with alternating bits, with all zeros and with all ones, so that bit order and reversed shifting show up. The readback bus returns a decoy byte unless select 7 is driven, which exposes a wrong select or a capture taken at the wrong time. Writes and breakpoint loads use asymmetric words that catch a swapped data/address order or a misplaced mode or trigger field. Requests held valid during a burst, unused op codes and a held step request tell apart ignoring, accepting and back-to-back acceptance.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  // request kinds
  localparam logic [2:0] OP_MEM_RD  = 3'd0;
  localparam logic [2:0] OP_MEM_WR  = 3'd1;
  localparam logic [2:0] OP_BKPT    = 3'd2;
  localparam logic [2:0] OP_STEP    = 3'd3;
  localparam logic [2:0] OP_TRC_CLR = 3'd4;

  // target command encodings
  localparam logic [2:0] PFX_BKPT_SHIFT = 3'b010;
  localparam logic [2:0] PFX_MEM_SHIFT  = 3'b110;
  localparam logic [3:0] CODE_STEP      = 4'b1000;
  localparam logic [3:0] CODE_TRC_CLR   = 4'b1010;
  localparam logic [3:0] CODE_MEM_RD    = 4'b1110;
  localparam logic [3:0] CODE_MEM_WR    = 4'b1111;
  localparam logic [3:0] CODE_IDLE      = 4'b0000;

  // readback select for the memory read result byte
  localparam logic [3:0] RB_SEL_MEM  = 4'd7;
  localparam logic [3:0] RB_SEL_IDLE = 4'd0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  function automatic logic op_known(input logic [2:0] op);
    return (op <= OP_TRC_CLR);
  endfunction

endpackage

// File: rtl/dbgseq_slot_timer.sv
module dbgseq_slot_timer #(
  parameter int LO_CYC = 4,
  parameter int HI_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe_hi,
  output logic slot_done
);

  localparam int SLOT_CYC = LO_CYC + HI_CYC;
  localparam int PW       = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  assign slot_done = run && (phase_q == PW'(SLOT_CYC - 1));
  assign strobe_hi = run && (phase_q >= PW'(LO_CYC));

  always_comb begin
    phase_d = phase_q;
    if (!run || slot_done) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/dbgseq_frame.sv
module dbgseq_frame
  import dbgseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MODE_W = 6,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [MODE_W-1:0] mode,
  input  logic [TRIG_W-1:0] trig,
  input  logic              advance,
  output logic [3:0]        code,
  output logic              last
);

  localparam int BP_W  = ADDR_W + MODE_W + TRIG_W;
  localparam int WR_W  = ADDR_W + DATA_W;
  localparam int PAY_W = (BP_W > WR_W) ? BP_W : WR_W;
  localparam int CNT_W = $clog2(PAY_W + 1);

  logic [PAY_W-1:0] pay_q,  pay_d;
  logic [CNT_W-1:0] bits_q, bits_d;
  logic [2:0]       pfx_q,  pfx_d;
  logic [3:0]       exe_q,  exe_d;
  logic             has_exe_q, has_exe_d;
  logic             shifting;

  assign shifting = (bits_q != '0);
  assign code     = shifting ? {pfx_q, pay_q[0]} : exe_q;
  assign last     = has_exe_q ? !shifting : (bits_q == CNT_W'(1));

  always_comb begin
    pay_d     = pay_q;
    bits_d    = bits_q;
    pfx_d     = pfx_q;
    exe_d     = exe_q;
    has_exe_d = has_exe_q;
    if (load) begin
      pay_d     = '0;
      bits_d    = '0;
      pfx_d     = PFX_MEM_SHIFT;
      exe_d     = CODE_IDLE;
      has_exe_d = 1'b1;
      case (op)
        OP_MEM_RD: begin
          pay_d[ADDR_W-1:0] = addr;
          bits_d            = CNT_W'(ADDR_W);
          exe_d             = CODE_MEM_RD;
        end
        OP_MEM_WR: begin
          pay_d[WR_W-1:0] = {addr, data};
          bits_d          = CNT_W'(WR_W);
          exe_d           = CODE_MEM_WR;
        end
        OP_BKPT: begin
          pay_d[BP_W-1:0] = {trig, mode, addr};
          bits_d          = CNT_W'(BP_W);
          pfx_d           = PFX_BKPT_SHIFT;
          has_exe_d       = 1'b0;
        end
        OP_STEP:    exe_d = CODE_STEP;
        OP_TRC_CLR: exe_d = CODE_TRC_CLR;
        default:    exe_d = CODE_IDLE;
      endcase
    end else if (advance && shifting) begin
      pay_d  = pay_q >> 1;
      bits_d = bits_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q     <= '0;
      bits_q    <= '0;
      pfx_q     <= '0;
      exe_q     <= '0;
      has_exe_q <= 1'b0;
    end else begin
      pay_q     <= pay_d;
      bits_q    <= bits_d;
      pfx_q     <= pfx_d;
      exe_q     <= exe_d;
      has_exe_q <= has_exe_d;
    end
  end

endmodule

// File: rtl/dbgseq_ctrl.sv
module dbgseq_ctrl
  import dbgseq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              slot_done,
  input  logic              last,
  input  logic [DATA_W-1:0] rb_data,
  output logic              accept,
  output logic              sending,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        rb_sel
);

  localparam int WW = $clog2(WAIT_CYC + 1);

  seq_state_e        st_q, st_d;
  logic [WW-1:0]     wcnt_q, wcnt_d;
  logic              is_rd_q, is_rd_d;
  logic              vld_d;
  logic              wait_end;

  assign req_ready = (st_q == ST_IDLE);
  assign sending   = (st_q == ST_SEND);
  assign accept    = req_ready && req_valid && op_known(req_op);
  assign wait_end  = (st_q == ST_WAIT) && (wcnt_q == WW'(WAIT_CYC - 1));
  assign rb_sel    = (st_q == ST_WAIT) ? RB_SEL_MEM : RB_SEL_IDLE;

  always_comb begin
    st_d    = st_q;
    wcnt_d  = '0;
    is_rd_d = is_rd_q;
    vld_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_SEND;
          is_rd_d = (req_op == OP_MEM_RD);
        end
      end
      ST_SEND: begin
        if (slot_done && last) begin
          st_d = is_rd_q ? ST_WAIT : ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (wait_end) begin
          st_d  = ST_IDLE;
          vld_d = 1'b1;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wcnt_q   <= '0;
      is_rd_q  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      st_q     <= st_d;
      wcnt_q   <= wcnt_d;
      is_rd_q  <= is_rd_d;
      rd_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (wait_end) begin
      rd_data <= rb_data;
    end
  end

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbgseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int MODE_W  = 6,
  parameter int TRIG_W  = 4,
  parameter int LO_CYC  = 4,
  parameter int HI_CYC  = 4,
  parameter int CLK_HZ  = 50_000_000,
  parameter int WAIT_NS = 10_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [TRIG_W-1:0] req_trig,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        cmd_code,
  output logic              cmd_strobe,
  output logic [3:0]        rb_sel,
  input  logic [DATA_W-1:0] rb_data
);

  localparam int WAIT_RAW = ((CLK_HZ / 1_000_000) * WAIT_NS) / 1000;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic       accept;
  logic       sending;
  logic       slot_done;
  logic       strobe_hi;
  logic       last;
  logic [3:0] frame_code;

  dbgseq_ctrl #(
    .DATA_W  (DATA_W),
    .WAIT_CYC(WAIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .slot_done(slot_done),
    .last     (last),
    .rb_data  (rb_data),
    .accept   (accept),
    .sending  (sending),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rb_sel   (rb_sel)
  );

  dbgseq_slot_timer #(
    .LO_CYC(LO_CYC),
    .HI_CYC(HI_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (sending),
    .strobe_hi(strobe_hi),
    .slot_done(slot_done)
  );

  dbgseq_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .MODE_W(MODE_W),
    .TRIG_W(TRIG_W)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (accept),
    .op     (req_op),
    .addr   (req_addr),
    .data   (req_data),
    .mode   (req_mode),
    .trig   (req_trig),
    .advance(slot_done),
    .code   (frame_code),
    .last   (last)
  );

  assign cmd_code   = sending ? frame_code : CODE_IDLE;
  assign cmd_strobe = strobe_hi;

endmodule

// File: rtl/dbgseq_checker.sv
module dbgseq_checker
  import dbgseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       req_ready,
  input logic       rd_valid,
  input logic [3:0] cmd_code,
  input logic       cmd_strobe,
  input logic [3:0] rb_sel
);

  // R2: code does not move while the strobe is high
  assert_code_steady_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && $past(cmd_strobe)) |-> $stable(cmd_code));

  // R2: the code is already set up in the low phase before the strobe rises
  assert_code_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_strobe) |-> $stable(cmd_code));

  // R7: read result is a single-cycle pulse
  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7: the captured byte was taken while select 7 was driven
  assert_rd_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rb_sel) == RB_SEL_MEM));

  // R8: accepting a request makes the block busy
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && op_known(req_op)) |=> !req_ready);

  // R10: an unused op leaves the block idle
  assert_unused_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !op_known(req_op)) |=> (req_ready && !cmd_strobe));

endmodule

bind dbg_cmd_seq dbgseq_checker u_dbgseq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .cmd_code  (cmd_code),
  .cmd_strobe(cmd_strobe),
  .rb_sel    (rb_sel)
);

// File: tb/tb_dbg_cmd_seq.sv
module tb_dbg_cmd_seq;

  localparam int LO  = 2;
  localparam int HI  = 3;
  localparam int HZ  = 50_000_000;
  localparam int WNS = 200;
  localparam int WCY = ((HZ / 1_000_000) * WNS) / 1000;   // 10 cycles

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [15:0] req_addr;
  logic [7:0]  req_data;
  logic [5:0]  req_mode;
  logic [3:0]  req_trig;
  logic        req_ready;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [3:0]  cmd_code;
  logic        cmd_strobe;
  logic [3:0]  rb_sel;
  logic [7:0]  rb_data;
  logic [7:0]  rb_val;

  // the target answers with the memory byte only on select 7
  assign rb_data = (rb_sel == 4'd7) ? rb_val : 8'hEE;

  dbg_cmd_seq #(
    .LO_CYC (LO),
    .HI_CYC (HI),
    .CLK_HZ (HZ),
    .WAIT_NS(WNS)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_mode  (req_mode),
    .req_trig  (req_trig),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .cmd_code  (cmd_code),
    .cmd_strobe(cmd_strobe),
    .rb_sel    (rb_sel),
    .rb_data   (rb_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0] code;
    logic       stb;
    logic       rdy;
    logic       vld;
    logic [3:0] sel;
    logic [7:0] dat;
    logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  function automatic exp_t idle_e();
    exp_t e;
    e = '{code: 4'd0, stb: 1'b0, rdy: 1'b1, vld: 1'b0, sel: 4'd0, dat: 8'd0, tag: 8'd9};
    return e;
  endfunction

  // R2: one slot = LO low cycles then HI high cycles with a steady code
  task automatic push_cmd(input logic [3:0] c, input int tag);
    exp_t e;
    e = '{code: c, stb: 1'b0, rdy: 1'b0, vld: 1'b0, sel: 4'd0, dat: 8'd0, tag: 8'(tag)};
    for (int i = 0; i < LO; i++) q.push_back(e);
    e.stb = 1'b1;
    for (int i = 0; i < HI; i++) q.push_back(e);
  endtask

  task automatic model_accept();
    logic [23:0] w24;
    logic [25:0] w26;
    exp_t e;
    case (req_op)
      3'd0: begin   // R3 read, then R7 wait and capture
        for (int i = 0; i < 16; i++) push_cmd({3'b110, req_addr[i]}, 3);
        push_cmd(4'b1110, 3);
        e = '{code: 4'd0, stb: 1'b0, rdy: 1'b0, vld: 1'b0, sel: 4'd7, dat: 8'd0, tag: 8'd7};
        for (int i = 0; i < WCY; i++) q.push_back(e);
        e = '{code: 4'd0, stb: 1'b0, rdy: 1'b1, vld: 1'b1, sel: 4'd0, dat: rb_val, tag: 8'd7};
        q.push_back(e);
      end
      3'd1: begin   // R4 write: data bits then address bits
        w24 = {req_addr, req_data};
        for (int i = 0; i < 24; i++) push_cmd({3'b110, w24[i]}, 4);
        push_cmd(4'b1111, 4);
      end
      3'd2: begin   // R5 breakpoint word
        w26 = {req_trig, req_mode, req_addr};
        for (int i = 0; i < 26; i++) push_cmd({3'b010, w26[i]}, 5);
      end
      3'd3: push_cmd(4'b1000, 6);   // R6 step
      3'd4: push_cmd(4'b1010, 6);   // R6 trace clear
      default: ;                    // R10 unused ops
    endcase
  endtask

  task automatic chk(input string what, input int tag, input int act, input int exp_v);
    n_vec++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL R%0d %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp_v);
    end
  endtask

  task automatic compare();
    chk("cmd_code", cur.tag, cmd_code, cur.code);
    chk("cmd_strobe", cur.tag, cmd_strobe, cur.stb);
    chk("req_ready", cur.rdy ? 9 : 8, req_ready, cur.rdy);
    chk("rd_valid", 7, rd_valid, cur.vld);
    chk("rb_sel", 7, rb_sel, cur.sel);
    if (cur.vld) chk("rd_data", 7, rd_data, cur.dat);
  endtask

  // one clock: model acceptance, advance, compare mid-cycle
  task automatic step();
    if (cur.rdy && req_valid) model_accept();
    @(negedge clk);
    cur = (q.size() > 0) ? q.pop_front() : idle_e();
    compare();
  endtask

  task automatic drain();
    while (q.size() > 0) step();
    step();
    step();
  endtask

  task automatic run_req(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d,
                         input logic [5:0] m, input logic [3:0] t);
    req_op = op; req_addr = a; req_data = d; req_mode = m; req_trig = t;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    drain();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_data = '0; req_mode = '0; req_trig = '0; rb_val = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cur = idle_e();
    cur.tag = 8'd1;
    compare();
    step(); step();

    // R3 / R7 reads with distinct address patterns
    rb_val = 8'h5A; run_req(3'd0, 16'hA5C3, 8'h00, 6'd0, 4'd0);
    rb_val = 8'h00; run_req(3'd0, 16'h0000, 8'h00, 6'd0, 4'd0);
    rb_val = 8'hFF; run_req(3'd0, 16'hFFFF, 8'h00, 6'd0, 4'd0);
    // R4 write
    run_req(3'd1, 16'h1234, 8'hF0, 6'd0, 4'd0);
    // R5 breakpoint with asymmetric fields
    run_req(3'd2, 16'hFFFE, 8'h00, 6'b100101, 4'b1010);
    run_req(3'd2, 16'h0001, 8'h00, 6'b010010, 4'b0001);
    // R6 step and trace clear
    run_req(3'd3, 16'h0000, 8'h00, 6'd0, 4'd0);
    run_req(3'd4, 16'h0000, 8'h00, 6'd0, 4'd0);
    // R10 unused ops held for several cycles
    for (int op = 5; op < 8; op++) begin
      req_op = 3'(op); req_valid = 1'b1;
      repeat (4) step();
    end
    req_valid = 1'b0; step();

    // R8 requests during a burst are ignored
    rb_val = 8'hC7;
    req_op = 3'd0; req_addr = 16'h8001; req_valid = 1'b1;
    step();
    req_op = 3'd1; req_addr = 16'h4444; req_data = 8'h99;
    repeat (30) step();
    req_valid = 1'b0;
    drain();

    // R9 a held step request is accepted back to back
    req_op = 3'd3; req_valid = 1'b1;
    repeat (2 * (LO + HI) + 1) step();
    req_valid = 1'b0;
    drain();

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule